// File: doc/BRIEF.md
# Outstanding Miss Tracking Table

This block keeps track of cache-line misses that have gone out to memory and not yet come back. The cache hands it each miss as a line address, a word offset within the line and a requester id. A miss to a line that no slot holds claims a free slot and produces one read request toward memory. A miss to a line that is already on its way is folded into the slot that holds it, so memory sees no second read. Each slot keeps a short list of waiting requests, one per merged miss, and each list element records the word that requester wants.

When memory returns a whole line, the slot that waits for it switches to answering its requesters. It sends one answer per cycle, in the order the misses were taken, each carrying the requester id and the word picked from the returned line. The slot goes back to the free pool in the same edge that retires its last answer. A stall output tells the cache that a miss cannot be taken in the current cycle, and the cache holds it and retries.

Top module: `mshr_file`

## Requirements
- R1: After reset no slot is in use: `mem_req_valid`, `resp_valid` and `alloc_stall` are all low while `alloc_valid` is low.
- R2: An accepted miss to a line held by no slot is followed, exactly one cycle after the accepting edge, by a one-cycle `mem_req_valid` with `mem_req_line` equal to that line.
- R3: An accepted miss to a line that a slot is still waiting on is merged into that slot and raises no memory request.
- R4: Every merged miss takes a list element of its own and keeps its own word offset, so misses to different words of one line get different words back.
- R5: Up to `N_ENT` distinct lines can be outstanding at once; a miss to a further new line while all slots are in use is stalled and not accepted.
- R6: A miss is stalled when the slot holding its line already has `N_SUB` list elements, or when that slot is already answering its requesters.
- R7: Starting the cycle after the edge that captures a fill for a waiting line, the slot gives one answer per cycle in the order its misses were taken; the answer word for offset k is bits [k*WORD_W +: WORD_W] of `fill_data`.
- R8: A slot is released at the edge that retires its last answer; a later miss to the same line is then taken as a new line and sends a new memory request.
- R9: A fill whose line no slot is waiting on is ignored and produces no answer.
- R10: Slots are taken lowest free index first, and when several slots hold returned lines the lowest index answers first, so a newly filled lower slot goes ahead of the rest of a higher slot's answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alloc_valid | input | 1 | A miss is presented |
| alloc_line | input | LINE_AW | Line address of the miss |
| alloc_off | input | OFF_W | Word offset within the line |
| alloc_id | input | ID_W | Requester id of the miss |
| alloc_stall | output | 1 | Miss cannot be taken this cycle |
| mem_req_valid | output | 1 | One-cycle read request to memory |
| mem_req_line | output | LINE_AW | Line address to read |
| fill_valid | input | 1 | Memory returns a line |
| fill_line | input | LINE_AW | Line address of the returned data |
| fill_data | input | (2**OFF_W)*WORD_W | Returned line, word k at bits [k*WORD_W +: WORD_W] |
| resp_valid | output | 1 | An answer is delivered |
| resp_id | output | ID_W | Requester id of the answer |
| resp_word | output | WORD_W | Word requested by that requester |

## Verification
The main stimulus sweeps the number of merged misses per line from one up to the list limit while every slot is filled with a distinct line, with offsets that rotate per line so that order errors and wrong word picks show up as id or word mismatches. At each fill level a miss to a fresh line and, at the list limit, an extra merge are tried to separate the two stall causes from a correct accept. Separate short runs cover a miss to a line that is already being answered, the reuse of a freed line, a fill for a line nobody waits on, and two fills one cycle apart where a lower slot has to overtake a higher one mid-way.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Life cycle of one tracking slot
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_WAIT  = 2'd1,
    ENT_DRAIN = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mshr_prio.sv
// Fixed-priority picker: lowest set request bit wins.
module mshr_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mshr_entry.sv
// One tracking slot: line address, ordered list of waiting requests, line data.
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int N_SUB   = 4,
  parameter int LINE_AW = 8,
  parameter int OFF_W   = 2,
  parameter int ID_W    = 4,
  parameter int WORD_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              alloc_en,
  input  logic                              merge_en,
  input  logic [LINE_AW-1:0]                req_line,
  input  logic [OFF_W-1:0]                  req_off,
  input  logic [ID_W-1:0]                   req_id,
  input  logic                              fill_en,
  input  logic [(1<<OFF_W)*WORD_W-1:0]      fill_data,
  input  logic                              pop_en,
  output logic                              waiting,
  output logic                              draining,
  output logic                              busy,
  output logic                              full,
  output logic                              last,
  output logic [LINE_AW-1:0]                line_o,
  output logic [ID_W-1:0]                   head_id,
  output logic [WORD_W-1:0]                 head_word
);

  localparam int WORDS  = 1 << OFF_W;
  localparam int SUB_IW = (N_SUB > 1) ? $clog2(N_SUB) : 1;
  localparam int CNT_W  = $clog2(N_SUB + 1);

  ent_state_e          state_q, state_d;
  logic [LINE_AW-1:0]  line_q;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SUB_IW-1:0]   head_q, head_d;
  logic [OFF_W-1:0]    off_q  [N_SUB];
  logic [ID_W-1:0]     id_q   [N_SUB];
  logic [WORD_W-1:0]   data_q [WORDS];
  logic                sub_we;
  logic [SUB_IW-1:0]   sub_wi;

  assign waiting   = (state_q == ENT_WAIT);
  assign draining  = (state_q == ENT_DRAIN);
  assign busy      = (state_q != ENT_FREE);
  assign full      = (cnt_q == CNT_W'(N_SUB));
  assign last      = ((CNT_W'(head_q) + CNT_W'(1)) == cnt_q);
  assign line_o    = line_q;
  assign head_id   = id_q[head_q];
  assign head_word = data_q[off_q[head_q]];

  assign sub_we = alloc_en | merge_en;
  assign sub_wi = alloc_en ? '0 : cnt_q[SUB_IW-1:0];

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    head_d  = head_q;
    if (alloc_en) begin
      state_d = ENT_WAIT;
      cnt_d   = CNT_W'(1);
      head_d  = '0;
    end else begin
      if (merge_en) cnt_d = cnt_q + CNT_W'(1);
      if (fill_en)  state_d = ENT_DRAIN;
      if (pop_en) begin
        if (last) state_d = ENT_FREE;
        else      head_d  = head_q + SUB_IW'(1);
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENT_FREE;
      cnt_q   <= '0;
      head_q  <= '0;
      line_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      head_q  <= head_d;
      if (alloc_en) line_q <= req_line;
    end
  end

  // Request list storage, enabled writes only
  always_ff @(posedge clk) begin
    if (sub_we) begin
      off_q[sub_wi] <= req_off;
      id_q[sub_wi]  <= req_id;
    end
  end

  // Returned line storage
  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int w = 0; w < WORDS; w++) data_q[w] <= fill_data[w*WORD_W +: WORD_W];
    end
  end

  AST_MERGE_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |-> (state_q == ENT_WAIT) && !full); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(N_SUB)); // R4
  AST_POP_ONLY_DRAINING: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (state_q == ENT_DRAIN)); // R7
  AST_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && last) |=> (state_q == ENT_FREE)); // R8
  AST_HOLD_BEFORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !last) |=> (state_q == ENT_DRAIN)); // R8

endmodule

// File: rtl/mshr_file.sv
// Table of outstanding line misses with merging of repeat misses.
module mshr_file
  import mshr_pkg::*;
#(
  parameter int N_ENT   = 4,
  parameter int N_SUB   = 4,
  parameter int LINE_AW = 8,
  parameter int OFF_W   = 2,
  parameter int ID_W    = 4,
  parameter int WORD_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_valid,
  input  logic [LINE_AW-1:0]            alloc_line,
  input  logic [OFF_W-1:0]              alloc_off,
  input  logic [ID_W-1:0]               alloc_id,
  output logic                          alloc_stall,
  output logic                          mem_req_valid,
  output logic [LINE_AW-1:0]            mem_req_line,
  input  logic                          fill_valid,
  input  logic [LINE_AW-1:0]            fill_line,
  input  logic [(1<<OFF_W)*WORD_W-1:0]  fill_data,
  output logic                          resp_valid,
  output logic [ID_W-1:0]               resp_id,
  output logic [WORD_W-1:0]             resp_word
);

  logic [N_ENT-1:0]   waiting, draining, busy, full, last;
  logic [N_ENT-1:0]   match_wait, match_drain, fill_hit;
  logic [N_ENT-1:0]   free_gnt, drain_gnt, alloc_en, merge_en;
  logic [LINE_AW-1:0] ent_line [N_ENT];
  logic [ID_W-1:0]    ent_id   [N_ENT];
  logic [WORD_W-1:0]  ent_word [N_ENT];
  logic               free_any, drain_any, hit_any, drain_hit, hit_full;
  logic               accept, new_line;
  logic               req_vld_d;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign match_wait[g]  = alloc_valid && waiting[g]  && (ent_line[g] == alloc_line);
    assign match_drain[g] = alloc_valid && draining[g] && (ent_line[g] == alloc_line);
    assign fill_hit[g]    = fill_valid  && waiting[g]  && (ent_line[g] == fill_line);
    assign alloc_en[g]    = new_line && free_gnt[g];
    assign merge_en[g]    = accept && match_wait[g];

    mshr_entry #(
      .N_SUB(N_SUB), .LINE_AW(LINE_AW), .OFF_W(OFF_W), .ID_W(ID_W), .WORD_W(WORD_W)
    ) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_en[g]), .merge_en(merge_en[g]),
      .req_line(alloc_line), .req_off(alloc_off), .req_id(alloc_id),
      .fill_en(fill_hit[g]), .fill_data(fill_data), .pop_en(drain_gnt[g]),
      .waiting(waiting[g]), .draining(draining[g]), .busy(busy[g]),
      .full(full[g]), .last(last[g]), .line_o(ent_line[g]),
      .head_id(ent_id[g]), .head_word(ent_word[g])
    );
  end

  mshr_prio #(.N(N_ENT)) u_free_pick  (.req(~busy),    .gnt(free_gnt),  .any(free_any));
  mshr_prio #(.N(N_ENT)) u_drain_pick (.req(draining), .gnt(drain_gnt), .any(drain_any));

  assign hit_any   = |match_wait;
  assign drain_hit = |match_drain;
  assign hit_full  = |(match_wait & full);

  assign alloc_stall = alloc_valid &&
                       (drain_hit || hit_full || (!hit_any && !free_any));
  assign accept      = alloc_valid && !alloc_stall;
  assign new_line    = accept && !hit_any;

  // Answer mux, one-hot select
  assign resp_valid = drain_any;
  always_comb begin
    resp_id   = '0;
    resp_word = '0;
    for (int i = 0; i < N_ENT; i++) begin
      resp_id   = resp_id   | ({ID_W{drain_gnt[i]}}   & ent_id[i]);
      resp_word = resp_word | ({WORD_W{drain_gnt[i]}} & ent_word[i]);
    end
  end

  // Memory request register
  assign req_vld_d = new_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
    end else begin
      mem_req_valid <= req_vld_d;
      if (new_line) mem_req_line <= alloc_line;
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_wait | match_drain)); // R3
  AST_REQ_FOR_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    new_line |=> mem_req_valid && (mem_req_line == $past(alloc_line))); // R2
  AST_NO_REQ_ON_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_any) |=> !mem_req_valid); // R3
  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && (&busy) && !hit_any) |-> alloc_stall); // R5
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drain_gnt)); // R7
  AST_FILL_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_hit)); // R9

endmodule

// File: tb/mshr_file_tb_top.sv
module mshr_file_tb_top;

  localparam int N_ENT   = 4;
  localparam int N_SUB   = 4;
  localparam int LINE_AW = 8;
  localparam int OFF_W   = 2;
  localparam int ID_W    = 4;
  localparam int WORD_W  = 16;
  localparam int WORDS   = 1 << OFF_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                    rst_n;
  logic                    alloc_valid;
  logic [LINE_AW-1:0]      alloc_line;
  logic [OFF_W-1:0]        alloc_off;
  logic [ID_W-1:0]         alloc_id;
  logic                    alloc_stall;
  logic                    mem_req_valid;
  logic [LINE_AW-1:0]      mem_req_line;
  logic                    fill_valid;
  logic [LINE_AW-1:0]      fill_line;
  logic [WORDS*WORD_W-1:0] fill_data;
  logic                    resp_valid;
  logic [ID_W-1:0]         resp_id;
  logic [WORD_W-1:0]       resp_word;

  mshr_file #(
    .N_ENT(N_ENT), .N_SUB(N_SUB), .LINE_AW(LINE_AW),
    .OFF_W(OFF_W), .ID_W(ID_W), .WORD_W(WORD_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_line(alloc_line), .alloc_off(alloc_off),
    .alloc_id(alloc_id), .alloc_stall(alloc_stall),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .resp_valid(resp_valid), .resp_id(resp_id), .resp_word(resp_word)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int q_wr  = 0;
  int q_rd  = 0;
  logic [ID_W-1:0]   q_id   [64];
  logic [WORD_W-1:0] q_word [64];

  function automatic logic [WORD_W-1:0] wexp(logic [LINE_AW-1:0] l, int o);
    return {l, 8'(o * 29 + 3)};
  endfunction

  function automatic logic [LINE_AW-1:0] sweep_line(int n, int j);
    return LINE_AW'(n * 32 + j * 3);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(int id, logic [LINE_AW-1:0] l, int o);
    q_id[q_wr % 64]   = ID_W'(id);
    q_word[q_wr % 64] = wexp(l, o);
    q_wr++;
  endtask

  task automatic do_alloc(logic [LINE_AW-1:0] l, int o, int id,
                          bit exp_stall, bit exp_req, string tag);
    @(negedge clk);
    alloc_valid = 1'b1;
    alloc_line  = l;
    alloc_off   = OFF_W'(o);
    alloc_id    = ID_W'(id);
    #1;
    chk({tag, " stall"}, int'(alloc_stall), int'(exp_stall));
    @(posedge clk);
    #1;
    chk({tag, " mem_req_valid"}, int'(mem_req_valid), int'(exp_req));
    if (exp_req) chk({tag, " mem_req_line"}, int'(mem_req_line), int'(l));
    alloc_valid = 1'b0;
  endtask

  task automatic set_fill(logic [LINE_AW-1:0] l);
    fill_valid = 1'b1;
    fill_line  = l;
    for (int w = 0; w < WORDS; w++) fill_data[w*WORD_W +: WORD_W] = wexp(l, w);
  endtask

  task automatic do_fill(logic [LINE_AW-1:0] l);
    @(negedge clk);
    set_fill(l);
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
  endtask

  task automatic wait_drain(string tag);
    for (int c = 0; c < 100 && q_rd != q_wr; c++) begin
      @(negedge clk);
      #2;
    end
    chk({tag, " answers left"}, q_wr - q_rd, 0);
  endtask

  // Answer monitor: order and content of every answer (R4, R7)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && resp_valid === 1'b1) begin
      if (q_rd == q_wr) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R7 unexpected answer actual=id %0h expected=none", resp_id);
      end else begin
        chk("R4/R7 answer id",   int'(resp_id),   int'(q_id[q_rd % 64]));
        chk("R4/R7 answer word", int'(resp_word), int'(q_word[q_rd % 64]));
        q_rd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    alloc_valid = 1'b0;
    alloc_line  = '0;
    alloc_off   = '0;
    alloc_id    = '0;
    fill_valid  = 1'b0;
    fill_line   = '0;
    fill_data   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 stall",         int'(alloc_stall),   0);
    chk("R1 mem_req_valid", int'(mem_req_valid), 0);
    chk("R1 resp_valid",    int'(resp_valid),    0);

    // Sweep: every slot used, 1..N_SUB merged misses per line (R2 R3 R4 R5 R6 R7 R8)
    for (int n = 1; n <= N_SUB; n++) begin
      for (int j = 0; j < N_ENT; j++)
        for (int k = 0; k < n; k++)
          do_alloc(sweep_line(n, j), (j + k) % WORDS, j * 4 + k, 1'b0, k == 0,
                   (k == 0) ? "R2 new line" : "R3 merge");
      do_alloc(8'hF0, 0, 0, 1'b1, 1'b0, "R5 table full");
      if (n == N_SUB) do_alloc(sweep_line(n, 0), 1, 15, 1'b1, 1'b0, "R6 list full");
      for (int j = 0; j < N_ENT; j++) begin
        for (int k = 0; k < n; k++) push(j * 4 + k, sweep_line(n, j), (j + k) % WORDS);
        do_fill(sweep_line(n, j));
      end
      wait_drain("R7 sweep");
    end

    // Miss to a line that is being answered (R6), then reuse of the freed line (R8)
    do_alloc(8'h55, 1, 6, 1'b0, 1'b1, "R2 line 55");
    do_alloc(8'h55, 3, 7, 1'b0, 1'b0, "R3 merge 55");
    push(6, 8'h55, 1);
    push(7, 8'h55, 3);
    do_fill(8'h55);
    do_alloc(8'h55, 0, 8, 1'b1, 1'b0, "R6 draining");
    wait_drain("R7 line 55");
    do_alloc(8'h55, 2, 9, 1'b0, 1'b1, "R8 reuse");
    push(9, 8'h55, 2);
    do_fill(8'h55);
    wait_drain("R8 reuse drain");

    // Fill for a line nobody waits on (R9)
    do_fill(8'h77);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      chk("R9 no answer", int'(resp_valid), 0);
    end

    // Lower slot overtakes a higher one mid-way (R10)
    do_alloc(8'h31, 0, 1, 1'b0, 1'b1, "R10 slot0");
    do_alloc(8'h31, 1, 2, 1'b0, 1'b0, "R10 slot0 merge");
    do_alloc(8'h32, 2, 3, 1'b0, 1'b1, "R10 slot1");
    do_alloc(8'h32, 3, 4, 1'b0, 1'b0, "R10 slot1 merge");
    push(3, 8'h32, 2);
    push(1, 8'h31, 0);
    push(2, 8'h31, 1);
    push(4, 8'h32, 3);
    @(negedge clk);
    set_fill(8'h32);
    @(posedge clk);
    #1;
    set_fill(8'h31);
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
    wait_drain("R10 order");

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule